// File: doc/BRIEF.md
# UART Receive Queue with Watermark Requests

This block is the receive side of a UART. It recovers bytes from the serial line with 16x oversampling and places them in a small queue. It raises a service request for a DMA engine or an interrupt once the number of queued bytes reaches a programmable threshold. The consumer takes one byte per acknowledge from the head of the queue. The byte on `rd_data` is valid whenever `fifo_cnt` is non-zero.

The block also detects an idle line and uses it to mark packet boundaries. Once the line has been quiet for a character time after the last byte, the request stays asserted, whatever the threshold, until the queue is empty. A bytes-remaining count below the threshold therefore never leaves a trailing byte stranded, where it would be taken as the first byte of the next packet. The boundary pulse is raised only after that drain has finished, so a handler that acts on it switches buffers only when nothing remains in the queue.

Top module: `uart_rx_dmaq`

## Requirements
- R1: One bit lasts 16 x `baud_div` clock cycles, and a divisor of 0 acts as 1. A frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. Bytes come out on `rd_data` in arrival order.
- R2: A start bit is confirmed at the eighth 1/16-bit tick after the falling edge. If the line is high again at that point, nothing is received and no packet is opened.
- R3: With the queue enabled, `dma_req` is high exactly when `fifo_cnt` is at or above the effective threshold. It is never high while `fifo_cnt` is 0.
- R4: The effective threshold is `watermark`, with 0 raised to 1 and any value of 4 or more lowered to 3. The queue depth is 4.
- R5: With `fifo_en` low, the queue holds a single byte and `dma_req` is high whenever that byte is present.
- R6: The line counts as idle after 160 ticks (ten bit times) of continuous high level following the stop-bit sample of a received byte. From then until the queue is empty, `dma_req` is held high regardless of the threshold.
- R7: `boundary` is a single-cycle pulse. It is raised once per idle event, only after the queue has been emptied, and only while `fifo_cnt` is 0.
- R8: A byte that arrives while the queue is full is discarded and sets `overrun`. `overrun` stays high until `err_clr` is pulsed.
- R9: Each acknowledge taken while `fifo_cnt` is non-zero removes one byte, and `fifo_cnt` and `dma_req` reflect the removal on the next cycle. An acknowledge on an empty queue changes nothing.
- R10: A stop bit sampled low sets the sticky `frame_err` flag, which is cleared by `err_clr`. The byte is still queued.
- R11: `fifo_cnt` never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_div | input | 8 | Clocks per 1/16-bit tick |
| watermark | input | 3 | Requested service threshold |
| fifo_en | input | 1 | 1: four-entry queue, 0: single byte |
| dma_ack | input | 1 | Pops the head byte |
| err_clr | input | 1 | Clears overrun and frame_err |
| rd_data | output | 8 | Head byte of the queue |
| dma_req | output | 1 | Service request |
| boundary | output | 1 | Packet-end pulse after draining |
| fifo_cnt | output | 3 | Bytes queued |
| overrun | output | 1 | Sticky byte-lost flag |
| frame_err | output | 1 | Sticky bad-stop flag |

## Verification
The threshold is swept over every code from 0 to 7 against packets of one to four bytes. Comparing the request with the clamped value before the idle point separates a correct clamp from an unclamped or off-by-one comparison. The same packets are then left to go idle. A request sampled shortly before and shortly after ten bit times tells early and late idle detection apart, and draining each packet checks byte order and that exactly one boundary pulse follows the last pop. Several divisors, including zero, test the bit timing; a short glitch, an oversized packet, single-byte mode and a low stop bit cover the remaining paths.

// File: rtl/uart_rx_dmaq.sv
`timescale 1ns/1ps
module uart_rx_dmaq #(
  parameter int DEPTH = 4,
  parameter int DIV_W = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [CNT_W-1:0] watermark,
  input  logic             fifo_en,
  input  logic             dma_ack,
  input  logic             err_clr,
  output logic [7:0]       rd_data,
  output logic             dma_req,
  output logic             boundary,
  output logic [CNT_W-1:0] fifo_cnt,
  output logic             overrun,
  output logic             frame_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CHAR_TICKS = 160;
  localparam int IW = $clog2(CHAR_TICKS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t              st;
  logic [1:0]       sync;
  logic             rx, rx_q;
  logic [DIV_W-1:0] divcnt;
  logic [3:0]       tcnt;
  logic [2:0]       bcnt;
  logic [7:0]       shreg;
  logic [IW-1:0]    idle_cnt;
  logic             armed, drain;
  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;

  wire [DIV_W-1:0] div_eff = (baud_div == '0) ? DIV_W'(1) : baud_div;
  wire tick = (divcnt == div_eff - DIV_W'(1));
  wire fall = (st == S_IDLE) && rx_q && !rx;
  wire push = (st == S_STOP) && tick && (tcnt == 4'd15);
  wire [CNT_W-1:0] cap  = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  wire full    = (fifo_cnt >= cap);
  wire do_push = push && !full;
  wire pop     = dma_ack && (fifo_cnt != '0);
  wire idle_hit = (st == S_IDLE) && rx && tick && armed && !push &&
                  (idle_cnt == IW'(CHAR_TICKS - 1));

  wire [CNT_W-1:0] wm_clamp = (watermark == '0) ? CNT_W'(1) :
                              (watermark >= CNT_W'(DEPTH)) ? CNT_W'(DEPTH - 1) : watermark;
  wire [CNT_W-1:0] wm_eff = fifo_en ? wm_clamp : CNT_W'(1);

  assign rx      = sync[1];
  assign rd_data = mem[rptr];
  assign dma_req = (fifo_cnt != '0) && ((fifo_cnt >= wm_eff) || drain);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync <= 2'b11;
      rx_q <= 1'b1;
    end else begin
      sync <= {sync[0], rxd};
      rx_q <= rx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        divcnt <= '0;
    else if (fall || tick) divcnt <= '0;
    else               divcnt <= divcnt + DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_IDLE;
      tcnt  <= '0;
      bcnt  <= '0;
      shreg <= '0;
    end else begin
      case (st)
        S_IDLE: if (fall) begin
          st   <= S_START;
          tcnt <= '0;
        end
        S_START: if (tick) begin
          if (tcnt == 4'd7) begin
            if (!rx) begin
              st   <= S_DATA;
              tcnt <= '0;
              bcnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            tcnt <= tcnt + 4'd1;
          end
        end
        S_DATA: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            shreg <= {rx, shreg[7:1]};
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) st <= S_STOP;
          end
        end
        S_STOP: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idle_cnt <= '0;
      armed    <= 1'b0;
      drain    <= 1'b0;
      boundary <= 1'b0;
    end else begin
      boundary <= 1'b0;
      if (push) begin
        armed    <= 1'b1;
        idle_cnt <= '0;
      end else if (st != S_IDLE || !rx) begin
        idle_cnt <= '0;
      end else if (tick && armed) begin
        idle_cnt <= idle_hit ? '0 : idle_cnt + IW'(1);
      end
      if (drain && fifo_cnt == '0 && !push) begin
        boundary <= 1'b1;
        drain    <= 1'b0;
      end
      if (idle_hit) begin
        drain <= 1'b1;
        armed <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      fifo_cnt <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop)     rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      fifo_cnt <= fifo_cnt + CNT_W'(do_push) - CNT_W'(pop);
    end

  always_ff @(posedge clk)
    if (do_push) mem[wptr] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      overrun   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (err_clr) begin
        overrun   <= 1'b0;
        frame_err <= 1'b0;
      end
      if (push && full) overrun   <= 1'b1;
      if (push && !rx)  frame_err <= 1'b1;
    end
endmodule

// File: rtl/uart_rx_dmaq_chk.sv
`timescale 1ns/1ps
module uart_rx_dmaq_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             dma_ack,
  input logic             err_clr,
  input logic             dma_req,
  input logic             boundary,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             overrun
);
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  // R5
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> fifo_cnt <= CNT_W'(1));

  // R5
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && fifo_cnt == CNT_W'(1)) |-> dma_req);

  // R3
  req_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> fifo_cnt != '0);

  // R4
  clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && fifo_cnt >= CNT_W'(DEPTH - 1)) |-> dma_req);

  // R7
  boundary_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> fifo_cnt == '0);

  // R7
  boundary_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> !boundary);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr) |=> overrun);

  // R9
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && fifo_cnt != '0) |=> fifo_cnt <= $past(fifo_cnt));
endmodule

bind uart_rx_dmaq uart_rx_dmaq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_ack(dma_ack),
  .err_clr(err_clr), .dma_req(dma_req), .boundary(boundary),
  .fifo_cnt(fifo_cnt), .overrun(overrun)
);

// File: tb/uart_rx_dmaq_tb.sv
`timescale 1ns/1ps
module uart_rx_dmaq_tb;
  logic       clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic [7:0] baud_div = 8'd1;
  logic [2:0] watermark = 3'd1;
  logic       fifo_en = 1'b1, dma_ack = 1'b0, err_clr = 1'b0;
  logic [7:0] rd_data;
  logic       dma_req, boundary, overrun, frame_err;
  logic [2:0] fifo_cnt;

  int nchk = 0, nfail = 0, nbnd = 0, div_e = 1;
  logic [7:0] exp_q [0:7];

  uart_rx_dmaq u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_div(baud_div),
    .watermark(watermark), .fifo_en(fifo_en), .dma_ack(dma_ack),
    .err_clr(err_clr), .rd_data(rd_data), .dma_req(dma_req),
    .boundary(boundary), .fifo_cnt(fifo_cnt), .overrun(overrun),
    .frame_err(frame_err)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (boundary) nbnd++;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic set_div(int d);
    baud_div = 8'(d);
    div_e = (d == 0) ? 1 : d;
  endtask

  task automatic wait_bits(int n);
    repeat (n * 16 * div_e) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b, logic stop_bit);
    rxd = 1'b0;
    wait_bits(1);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      wait_bits(1);
    end
    rxd = stop_bit;
    wait_bits(1);
    rxd = 1'b1;
  endtask

  task automatic pop_one(logic [7:0] exp, string tag);
    chk(tag, int'(rd_data), int'(exp));
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  task automatic drain_all(int k, int b0);
    for (int j = 0; j < k; j++) begin
      chk("R6 request held during flush", int'(dma_req), 1);
      pop_one(exp_q[j], "R1 data order");
      chk("R9 count after pop", int'(fifo_cnt), k - j - 1);
    end
    repeat (3) @(negedge clk);
    chk("R7 boundary after drain", nbnd, b0 + 1);
    chk("R6 request off when empty", int'(dma_req), 0);
  endtask

  task automatic packet(int k, int wm);
    int wme, b0;
    wme = (wm == 0) ? 1 : (wm >= 4) ? 3 : wm;
    b0 = nbnd;
    fifo_en = 1'b1;
    watermark = 3'(wm);
    for (int j = 0; j < k; j++) begin
      exp_q[j] = 8'((j * 37 + wm * 11 + k * 71 + 5) & 255);
      send_byte(exp_q[j], 1'b1);
    end
    chk("R1 count after packet", int'(fifo_cnt), k);
    chk("R3 R4 request vs threshold", int'(dma_req), int'(k >= wme));
    chk("R7 no boundary before idle", nbnd, b0);
    if (k < wme) begin
      wait_bits(8);
      chk("R6 no flush before idle", int'(dma_req), 0);
      wait_bits(3);
    end else begin
      wait_bits(11);
    end
    chk("R6 flush request after idle", int'(dma_req), 1);
    drain_all(k, b0);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    @(negedge clk);
    chk("R9 ack on empty ignored", int'(fifo_cnt), 0);
    repeat (4) @(negedge clk);
    chk("R7 single pulse", nbnd, b0 + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL all requirements: watchdog expired, actual running expected finished");
    report();
  end

  initial begin
    int b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset fifo_cnt", int'(fifo_cnt), 0);
    chk("reset dma_req", int'(dma_req), 0);
    chk("reset boundary", int'(boundary), 0);
    chk("reset overrun", int'(overrun), 0);
    chk("reset frame_err", int'(frame_err), 0);

    set_div(1);
    for (int wm = 0; wm < 8; wm++)
      for (int k = 1; k <= 4; k++)
        packet(k, wm);

    // R1 divisor sweep, zero acting as one
    for (int d = 0; d < 6; d++) begin
      set_div(d);
      packet(2, 2);
    end
    set_div(1);

    // R2 false start
    b0 = nbnd;
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    wait_bits(13);
    chk("R2 glitch not received", int'(fifo_cnt), 0);
    chk("R2 glitch opens no packet", nbnd, b0);
    chk("R2 no framing error", int'(frame_err), 0);
    packet(1, 1);

    // R8 overrun
    fifo_en = 1'b1;
    watermark = 3'd3;
    b0 = nbnd;
    for (int j = 0; j < 5; j++) begin
      exp_q[j] = 8'(8'hC0 + j);
      send_byte(exp_q[j], 1'b1);
    end
    chk("R8 count capped at depth", int'(fifo_cnt), 4);
    chk("R8 overrun set", int'(overrun), 1);
    wait_bits(11);
    drain_all(4, b0);
    chk("R8 overrun sticky", int'(overrun), 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
    chk("R8 overrun cleared", int'(overrun), 0);

    // R5 single-byte mode
    fifo_en = 1'b0;
    watermark = 3'd3;
    b0 = nbnd;
    send_byte(8'h3C, 1'b1);
    chk("R5 one byte held", int'(fifo_cnt), 1);
    chk("R5 request per byte", int'(dma_req), 1);
    send_byte(8'hA7, 1'b1);
    chk("R5 second byte overruns", int'(overrun), 1);
    chk("R5 still one byte", int'(fifo_cnt), 1);
    wait_bits(11);
    exp_q[0] = 8'h3C;
    drain_all(1, b0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;

    // R10 framing error
    fifo_en = 1'b1;
    watermark = 3'd1;
    b0 = nbnd;
    @(negedge clk);
    send_byte(8'h5A, 1'b0);
    chk("R10 frame_err set", int'(frame_err), 1);
    chk("R10 byte still queued", int'(fifo_cnt), 1);
    wait_bits(12);
    exp_q[0] = 8'h5A;
    drain_all(1, b0);
    chk("R10 frame_err sticky", int'(frame_err), 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
    chk("R10 frame_err cleared", int'(frame_err), 0);

    report();
  end
endmodule